// File: doc/BRIEF.md
# Legacy-Mode IDE Configuration Register File

This block holds the configuration space of a two-channel IDE storage function. A host-side front end presents accesses as a dword index, four byte-lane enables and write data. One access can be a single byte, a word or a whole dword. Each byte has a fixed reset value and a write mask. Bytes outside the implemented set read as zero, and writes to them are dropped. Read data comes back one cycle after the request, with a valid strobe.

The programming-interface byte selects how each channel is addressed. While its low nibble holds the legacy code 0xA:
- The four command/control base-address registers (bytes 0x10 to 0x1F) read as zero.
- The bus-master base address at 0x20 returns 0xCC01 when it still holds only its I/O-space flag.

Two more outputs derive from this state:
- A per-channel native/legacy output follows the writable bits of the programming-interface byte.
- Each channel's interrupt input passes straight through to an output. Its level is also sampled into bit 7 of a per-channel status byte.

Top module: `ide_cfg_space`

## Requirements
- R1: After reset the programming-interface byte (byte 0x09, read as lane 1 of dword 2) is 0x8A, so dword 2 reads 0x01018A01, and `chan_native` is all zero.
- R2: Only bits 0 and 2 of the programming-interface byte accept writes. `chan_native[n]` equals bit 2n of that byte. The output changes only in the cycle after a write with lane 1 of dword 2 enabled.
- R3: Legacy mode is active while the low nibble of the programming-interface byte is 0xA. In that mode, any read of dwords 4 to 7 returns zero on every lane. Outside it, those dwords return their stored values; the stored base registers take write masks 0xFFF8, 0xFFFC, 0xFFF8, 0xFFFC, with bit 0 fixed at 1.
- R4: In legacy mode, a read of dword 8 with lane 0 enabled returns 0xCC01 (masked to the enabled lanes) when the enabled stored bytes equal 0x00000001. It returns the stored value in every other case. Dword 8 resets to 0x00000001 and has write mask 0x0000FFF0.
- R5: Byte 0x3C is read-only and reads 0x0E.
- R6: For channel n, bit 7 of byte 0x70+8n reflects the `irq_in[n]` level sampled at the previous clock edge, and writes to that byte have no effect. `irq_out[n]` equals `irq_in[n]` at all times.
- R7: Reset values:
  - Dwords 0x40, 0x44, 0x48, 0x4C, 0x50, 0x54 reset to 0x0A090600, 0x00C00068, 0xA8A8A8A8, 0x000000FF, 0x07070707, 0x00000004.
  - Dwords 0x60 and 0x68 reset to 0x00000200.
  - Dword 0xC0 resets to 0x00020001 and is read-only.
  - Byte 0x34 reads 0xC0.
- R8: Dword 0x04 resets to 0x02800081, with I/O enable bit 0, wait-cycle bit 7, fast back-to-back status bit 23 and medium select timing bits 26:25 = 01. Only bits 0, 1, 2 and 7 are writable.
- R9: A write updates byte lane k only when `acc_be[k]` is 1, and only in the bits its mask allows. Dwords 0x40 to 0x57, 0x60 and 0x68 are fully writable.
- R10: A read of an unimplemented dword (for example 0x80 or 0x0C) returns zero, also after a write to it.
- R11: `rd_valid` rises in the cycle after each read request and only then. Lanes not enabled in the request read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dw | input | 6 | Dword index (byte offset / 4) |
| acc_be | input | 4 | Byte-lane enables |
| acc_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_in | input | N_CHAN | Channel interrupt levels |
| irq_out | output | N_CHAN | Channel interrupt levels passed through |
| chan_native | output | N_CHAN | 1 = channel uses native addressing |

## Verification
Two functions can land on the same status byte in one cycle:
- an interrupt edge sets or clears bit 7 of a status byte;
- a host write targets that same byte.

The bench raises `irq_in[0]` on the very cycle that it writes 0x00 to dword 0x70. A later read must still show 0x80, since the level wins and the write is dropped. A second collision comes from a mode write: it is followed at once by reads of the hidden base registers and the bus-master base. This proves that the hiding and the 0xCC01 substitution follow the new mode from the next cycle on.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
   localparam int CFG_ADDR_W  = 8;
   localparam int CFG_BYTES   = 1 << CFG_ADDR_W;
   localparam int DW_W        = CFG_ADDR_W - 2;
   localparam int OFF_PROGIF  = 9;
   localparam int DW_BAR_LO   = 4;
   localparam int DW_BAR_HI   = 7;
   localparam int DW_DMA_BAR  = 8;
   localparam int OFF_STAT0   = 'h70;
   localparam int STAT_STRIDE = 8;

   function automatic bit dw_impl(int unsigned dw);
      case (dw)
         0, 1, 2, 4, 5, 6, 7, 8, 13, 15,
         16, 17, 18, 19, 20, 21, 24, 26, 28, 30, 48: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] dw_reset(int unsigned dw);
      case (dw)
         0:  return 32'h2A10_1F3C;
         1:  return 32'h0280_0081;
         2:  return 32'h0101_8A01;
         4, 5, 6, 7, 8: return 32'h0000_0001;
         13: return 32'h0000_00C0;
         15: return 32'h0000_000E;
         16: return 32'h0A09_0600;
         17: return 32'h00C0_0068;
         18: return 32'hA8A8_A8A8;
         19: return 32'h0000_00FF;
         20: return 32'h0707_0707;
         21: return 32'h0000_0004;
         24, 26: return 32'h0000_0200;
         48: return 32'h0002_0001;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] dw_wmask(int unsigned dw);
      case (dw)
         1:  return 32'h0000_0087;
         2:  return 32'h0000_0500;
         4, 6: return 32'h0000_FFF8;
         5, 7: return 32'h0000_FFFC;
         8:  return 32'h0000_FFF0;
         16, 17, 18, 19, 20, 21, 24, 26: return 32'hFFFF_FFFF;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [7:0] lane_of(logic [31:0] v, int unsigned lane);
      return v[lane*8 +: 8];
   endfunction
endpackage

// File: rtl/ide_cfg_byte.sv
module ide_cfg_byte #(
   parameter logic [7:0] RST   = 8'h00,
   parameter logic [7:0] WMASK = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wd,
   output logic [7:0] q
);
   generate
      if (WMASK == 8'h00) begin : g_ro
         logic unused_ro;
         assign unused_ro = ^{clk, rst_n, we, wd};
         assign q = RST;
      end else begin : g_rw
         logic [7:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  r <= RST;
            else if (we) r <= (r & ~WMASK) | (wd & WMASK);
         end
         assign q = r;
      end
   endgenerate
endmodule

// File: rtl/ide_irq_mirror.sv
module ide_irq_mirror #(
   parameter int N_CHAN = 2
) (
   input  logic              clk,
   input  logic [N_CHAN-1:0] irq_i,
   output logic [N_CHAN-1:0] irq_o,
   output logic [N_CHAN-1:0] st_o
);
   // level sample kept without reset so it tracks the pin from the first edge
   logic [N_CHAN-1:0] st_q;
   always_ff @(posedge clk) st_q <= irq_i;
   assign st_o  = st_q;
   assign irq_o = irq_i;
endmodule

// File: rtl/ide_cfg_rdmux.sv
module ide_cfg_rdmux
   import ide_cfg_pkg::*;
#(
   parameter logic [15:0] DMA_DFLT = 16'hCC00
) (
   input  logic [7:0]      bytes_i [CFG_BYTES],
   input  logic [DW_W-1:0] dw_i,
   input  logic [3:0]      be_i,
   input  logic            legacy_i,
   output logic [31:0]     data_o
);
   logic [31:0] raw, lane_m;
   logic        hide, subst;

   always_comb begin
      for (int l = 0; l < 4; l++) begin
         lane_m[l*8 +: 8] = {8{be_i[l]}};
         raw[l*8 +: 8]    = bytes_i[{dw_i, 2'(l)}] & {8{be_i[l]}};
      end
   end

   assign hide  = legacy_i && (int'(dw_i) >= DW_BAR_LO) && (int'(dw_i) <= DW_BAR_HI);
   assign subst = legacy_i && (int'(dw_i) == DW_DMA_BAR) && be_i[0] && (raw == 32'h1);

   always_comb begin
      if (hide)       data_o = '0;
      else if (subst) data_o = {16'h0, DMA_DFLT | 16'h0001} & lane_m;
      else            data_o = raw;
   end
endmodule

// File: rtl/ide_cfg_space.sv
module ide_cfg_space
   import ide_cfg_pkg::*;
#(
   parameter int          N_CHAN      = 2,
   parameter int          RD_REG      = 1,
   parameter logic [3:0]  LEGACY_CODE = 4'hA,
   parameter logic [15:0] DMA_DFLT    = 16'hCC00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [DW_W-1:0]   acc_dw,
   input  logic [3:0]        acc_be,
   input  logic [31:0]       acc_wdata,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   input  logic [N_CHAN-1:0] irq_in,
   output logic [N_CHAN-1:0] irq_out,
   output logic [N_CHAN-1:0] chan_native
);
   initial begin
      if (N_CHAN < 1 || N_CHAN > 2) $error("N_CHAN must be 1 or 2");
      if (RD_REG < 0 || RD_REG > 1) $error("RD_REG must be 0 or 1");
      if (OFF_STAT0 + STAT_STRIDE * (N_CHAN - 1) >= CFG_BYTES) $error("status byte out of range");
   end

   logic              wr_en, rd_req, legacy;
   logic [7:0]        cfg_q   [CFG_BYTES];
   logic [7:0]        rd_bytes[CFG_BYTES];
   logic [CFG_BYTES-1:0] we_b;
   logic [N_CHAN-1:0] irq_st;
   logic [7:0]        progif;
   logic [31:0]       mux_data;
   logic [(1<<DW_W)-1:0] impl_vec;

   assign wr_en  = acc_valid && acc_write;
   assign rd_req = acc_valid && !acc_write;

   generate
      for (genvar d = 0; d < (1 << DW_W); d++) begin : g_impl
         assign impl_vec[d] = dw_impl(d);
      end

      for (genvar i = 0; i < CFG_BYTES; i++) begin : g_byte
         localparam int DW   = i / 4;
         localparam int LANE = i % 4;
         localparam int CH   = (i - OFF_STAT0) / STAT_STRIDE;
         assign we_b[i] = wr_en && (acc_dw == DW_W'(DW)) && acc_be[LANE];
         if (dw_impl(DW)) begin : g_cell
            ide_cfg_byte #(
               .RST  (lane_of(dw_reset(DW), LANE)),
               .WMASK(lane_of(dw_wmask(DW), LANE))
            ) u_cell (
               .clk  (clk),
               .rst_n(rst_n),
               .we   (we_b[i]),
               .wd   (acc_wdata[LANE*8 +: 8]),
               .q    (cfg_q[i])
            );
         end else begin : g_none
            assign cfg_q[i] = 8'h00;
         end
         if (i >= OFF_STAT0 && ((i - OFF_STAT0) % STAT_STRIDE) == 0 && CH < N_CHAN) begin : g_stat
            assign rd_bytes[i] = cfg_q[i] | {irq_st[CH], 7'b0};
         end else begin : g_plain
            assign rd_bytes[i] = cfg_q[i];
         end
      end
   endgenerate

   assign progif = cfg_q[OFF_PROGIF];
   assign legacy = (progif[3:0] == LEGACY_CODE);

   generate
      for (genvar n = 0; n < N_CHAN; n++) begin : g_mode
         assign chan_native[n] = progif[2*n];
      end
   endgenerate

   ide_irq_mirror #(.N_CHAN(N_CHAN)) u_irq (
      .clk  (clk),
      .irq_i(irq_in),
      .irq_o(irq_out),
      .st_o (irq_st)
   );

   ide_cfg_rdmux #(.DMA_DFLT(DMA_DFLT)) u_rdmux (
      .bytes_i (rd_bytes),
      .dw_i    (acc_dw),
      .be_i    (acc_be),
      .legacy_i(legacy),
      .data_o  (mux_data)
   );

   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && acc_dw == DW_W'(2) && acc_be[1]) |=> $stable(chan_native));

   generate
      if (RD_REG == 1) begin : g_rreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_valid <= 1'b0;
               rd_data  <= '0;
            end else begin
               rd_valid <= rd_req;
               if (rd_req) rd_data <= mux_data;
            end
         end

         // R11
         rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req |=> rd_valid);
         // R11
         rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_req |=> !rd_valid);
         // R3
         legacy_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req && legacy && acc_dw >= DW_W'(DW_BAR_LO) && acc_dw <= DW_W'(DW_BAR_HI))
            |=> (rd_data == 32'h0));
         // R10
         unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req && !impl_vec[acc_dw]) |=> (rd_data == 32'h0));
         // R6
         irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req && acc_dw == DW_W'(OFF_STAT0 / 4) && acc_be[0])
            |=> (rd_data[7] == $past(irq_in[0], 2)));
      end else begin : g_rcomb
         assign rd_valid = rd_req;
         assign rd_data  = rd_req ? mux_data : 32'h0;
      end
   endgenerate
endmodule

// File: tb/ide_cfg_space_tb.sv
module ide_cfg_space_tb;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [5:0]  acc_dw = '0;
   logic [3:0]  acc_be = '0;
   logic [31:0] acc_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [1:0]  irq_in = 2'b00, irq_out, chan_native;

   int total = 0, bad = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   ide_cfg_space u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_dw(acc_dw), .acc_be(acc_be), .acc_wdata(acc_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .irq_in(irq_in),
      .irq_out(irq_out), .chan_native(chan_native)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
      acc_valid = 1'b1; acc_write = 1'b1; acc_dw = dw; acc_be = be; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic rd(logic [5:0] dw, logic [3:0] be, logic [31:0] exp, string tag);
      acc_valid = 1'b1; acc_write = 1'b0; acc_dw = dw; acc_be = be;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   // monitor: pops one expected item per returned read
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) check("R11 unexpected rd_valid", 32'h1, 32'h0);
         else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   initial begin
      #(CLK_P * 50000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 native after reset", {30'h0, chan_native}, 32'h0);
      check("R11 rd_valid idle", {31'h0, rd_valid}, 32'h0);

      rd(6'd2,  4'hF, 32'h0101_8A01, "R1 progif reset");
      rd(6'd1,  4'hF, 32'h0280_0081, "R8 command/status reset");
      rd(6'd13, 4'hF, 32'h0000_00C0, "R7 capability pointer");
      rd(6'd15, 4'hF, 32'h0000_000E, "R5 interrupt line reset");
      rd(6'd16, 4'hF, 32'h0A09_0600, "R7 dword 0x40");
      rd(6'd17, 4'hF, 32'h00C0_0068, "R7 dword 0x44");
      rd(6'd18, 4'hF, 32'hA8A8_A8A8, "R7 dword 0x48");
      rd(6'd19, 4'hF, 32'h0000_00FF, "R7 dword 0x4C");
      rd(6'd20, 4'hF, 32'h0707_0707, "R7 dword 0x50");
      rd(6'd21, 4'hF, 32'h0000_0004, "R7 dword 0x54");
      rd(6'd24, 4'hF, 32'h0000_0200, "R7 dword 0x60");
      rd(6'd26, 4'hF, 32'h0000_0200, "R7 dword 0x68");
      rd(6'd48, 4'hF, 32'h0002_0001, "R7 dword 0xC0");

      wr(6'd1, 4'hF, 32'hFFFF_FFFF);
      rd(6'd1, 4'hF, 32'h0280_0087, "R8 command mask");
      wr(6'd48, 4'hF, 32'h0);
      rd(6'd48, 4'hF, 32'h0002_0001, "R7 dword 0xC0 read-only");
      wr(6'd15, 4'hF, 32'hFFFF_FFFF);
      rd(6'd15, 4'hF, 32'h0000_000E, "R5 interrupt line read-only");

      wr(6'd18, 4'b0101, 32'h1122_3344);
      rd(6'd18, 4'hF, 32'hA822_A844, "R9 lane-masked write");
      rd(6'd18, 4'b0011, 32'h0000_A844, "R11 lanes off read zero");

      wr(6'd4, 4'hF, 32'hFFFF_FFFF);
      rd(6'd4, 4'hF, 32'h0, "R3 BAR0 hidden in legacy");
      rd(6'd7, 4'b1100, 32'h0, "R3 BAR3 word hidden");
      rd(6'd8, 4'hF, 32'h0000_CC01, "R4 dword substitute");
      rd(6'd8, 4'b0011, 32'h0000_CC01, "R4 word substitute");
      rd(6'd8, 4'b0001, 32'h0000_0001, "R4 byte substitute");
      rd(6'd8, 4'b0010, 32'h0, "R4 no lane0 no substitute");

      wr(6'd32, 4'hF, 32'hFFFF_FFFF);
      rd(6'd32, 4'hF, 32'h0, "R10 unimplemented 0x80");
      rd(6'd3,  4'hF, 32'h0, "R10 unimplemented 0x0C");

      wr(6'd2, 4'b0010, 32'h0000_FF00);
      check("R2 native after 0xFF", {30'h0, chan_native}, 32'h3);
      rd(6'd2, 4'hF, 32'h0101_8F01, "R2 progif mask");
      rd(6'd4, 4'hF, 32'h0000_FFF9, "R3 BAR0 visible native");
      rd(6'd8, 4'hF, 32'h0000_0001, "R4 no substitute native");
      wr(6'd2, 4'b0010, 32'h0000_0400);
      check("R2 native ch1 only", {30'h0, chan_native}, 32'h2);
      wr(6'd2, 4'b1101, 32'hFFFF_00FF);
      check("R2 lane1 off keeps mode", {30'h0, chan_native}, 32'h2);
      wr(6'd2, 4'b0010, 32'h0);
      check("R2 back to legacy", {30'h0, chan_native}, 32'h0);
      rd(6'd4, 4'hF, 32'h0, "R3 hidden again");

      wr(6'd8, 4'hF, 32'h0000_D005);
      rd(6'd8, 4'hF, 32'h0000_D001, "R4 programmed base kept");

      irq_in[0] = 1'b1;
      #1 check("R6 irq_out follows ch0", {30'h0, irq_out}, 32'h1);
      wr(6'd28, 4'b0001, 32'h0);
      rd(6'd28, 4'hF, 32'h0000_0080, "R6 status set despite write");
      rd(6'd30, 4'hF, 32'h0, "R6 ch1 status clear");
      irq_in = 2'b10;
      #1 check("R6 irq_out follows ch1", {30'h0, irq_out}, 32'h2);
      @(negedge clk);
      rd(6'd28, 4'hF, 32'h0, "R6 ch0 status cleared");
      rd(6'd30, 4'hF, 32'h0000_0080, "R6 ch1 status set");
      irq_in = 2'b00;
      @(negedge clk);
      rd(6'd30, 4'hF, 32'h0, "R6 ch1 status cleared");

      repeat (3) @(negedge clk);
      check("R11 all reads returned", exp_q.size(), 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule